// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

This core runs one instruction in each clock cycle. It covers a small subset of a classic three-format load/store instruction set: register-register add, sub, and, or and slt, plus addi, lw, sw, beq and j. Each instruction is fetched through a combinational instruction port. Its two source registers are read from a 32 x 32-bit register file, and the ALU computes a result or an address. The data port is read or written, and the next PC is chosen. All of this happens between two rising edges.

Decoding works in two levels. A main decoder sorts the opcode into an instruction class (R-type, load, store, branch, jump, add-immediate, or no-op). From that class it produces the datapath controls and a 2-bit ALU selector. A local ALU decoder then combines the selector with the funct field to give a 4-bit ALU operation. The single state element is the program counter, plus the register file. The PC register updates on each edge. The output process drives the memory ports from the decoded class.

Both memories sit outside the core and are read combinationally. A data write takes effect on the clock edge while the write strobe is high.

Top module: `sc_core`

## Requirements
- R1: While reset (active low, asynchronous) is asserted, the PC is 0. All 32 registers read as 0 after reset. The first instruction fetched after release is at address 0.
- R2: Opcode 0 (R-type) writes register rd (bits 15:11) with rs (bits 25:21) op rt (bits 20:16). The operation is set by funct (bits 5:0): 32 add, 34 subtract, 36 AND, 37 OR, 42 signed set-on-less-than (result 1 or 0).
- R3: An R-type instruction with any other funct value writes no register, and the PC advances by 4.
- R4: Opcode 8 (addi) writes rt with rs plus the sign-extended 16-bit immediate (bits 15:0).
- R5: Opcode 35 (lw) writes rt with the data-port read value. The data address is rs plus the sign-extended immediate, and the write strobe stays low.
- R6: Opcode 43 (sw) raises the data write strobe. The data address is rs plus the sign-extended immediate, and the write data is rt. No other opcode raises the strobe.
- R7: Opcode 4 (beq) compares rs with rt. When they are equal, the next PC is PC+4 plus the sign-extended immediate shifted left by 2, which can be forward or backward. Otherwise the next PC is PC+4.
- R8: Opcode 2 (j) loads the PC with PC[31:28], then the 26-bit target (bits 25:0), then two zero bits.
- R9: Register 0 always reads as 0, and a write aimed at it has no effect.
- R10: Any opcode other than 0, 2, 4, 8, 35 and 43 writes nothing and advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 32 | Current PC, the instruction fetch address |
| imem_rdata | input | 32 | Instruction word at imem_addr |
| dmem_addr | output | 32 | Data address (ALU result) |
| dmem_wdata | output | 32 | Store data (register rt) |
| dmem_we | output | 1 | Data write strobe, high only for sw |
| dmem_rdata | input | 32 | Data word read at dmem_addr |

## Verification
Two kinds of result are due, at different times. The fetch address and the data-port strobe, address and write data for an instruction are valid in the same cycle that the instruction is on the instruction port. The effect of a register write, a branch or a jump shows one edge later: as the next fetch address, or in a later store. The bench runs a behavioural interpreter of the instruction set in lockstep with the core. At each falling edge it compares the settled port values for the current instruction, then advances its own model by one instruction to match the next rising edge. Register contents become visible through stores, which the bench checks word by word at the end.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam logic [5:0] OPC_RTYPE = 6'd0;
    localparam logic [5:0] OPC_JUMP  = 6'd2;
    localparam logic [5:0] OPC_BEQ   = 6'd4;
    localparam logic [5:0] OPC_ADDI  = 6'd8;
    localparam logic [5:0] OPC_LOAD  = 6'd35;
    localparam logic [5:0] OPC_STORE = 6'd43;

    localparam logic [5:0] FN_ADD = 6'd32;
    localparam logic [5:0] FN_SUB = 6'd34;
    localparam logic [5:0] FN_AND = 6'd36;
    localparam logic [5:0] FN_OR  = 6'd37;
    localparam logic [5:0] FN_SLT = 6'd42;

    // selector from the main decoder to the local ALU decoder
    typedef enum logic [1:0] {
        ASEL_ADD   = 2'b00,
        ASEL_SUB   = 2'b01,
        ASEL_FUNCT = 2'b10
    } alu_sel_e;

    typedef enum logic [3:0] {
        AOP_AND = 4'b0000,
        AOP_OR  = 4'b0001,
        AOP_ADD = 4'b0010,
        AOP_SUB = 4'b0110,
        AOP_SLT = 4'b0111,
        AOP_NOR = 4'b1100
    } alu_op_e;

    typedef enum logic [2:0] {
        CLS_RTYPE,
        CLS_LOAD,
        CLS_STORE,
        CLS_BRANCH,
        CLS_JUMP,
        CLS_ADDI,
        CLS_NOP
    } ins_cls_e;

    typedef struct packed {
        logic     reg_we;
        logic     dst_rd;
        logic     src_imm;
        logic     wb_mem;
        logic     mem_we;
        logic     branch;
        logic     jump;
        alu_sel_e alu_sel;
    } ctrl_t;

endpackage

// File: rtl/sc_main_dec.sv
module sc_main_dec
    import sc_pkg::*;
(
    input  logic [5:0] opcode,
    output ins_cls_e   cls,
    output ctrl_t      ctrl
);

    always_comb begin
        unique case (opcode)
            OPC_RTYPE: cls = CLS_RTYPE;
            OPC_LOAD:  cls = CLS_LOAD;
            OPC_STORE: cls = CLS_STORE;
            OPC_BEQ:   cls = CLS_BRANCH;
            OPC_JUMP:  cls = CLS_JUMP;
            OPC_ADDI:  cls = CLS_ADDI;
            default:   cls = CLS_NOP;
        endcase
    end

    always_comb begin
        ctrl = '{reg_we: 1'b0, dst_rd: 1'b0, src_imm: 1'b0, wb_mem: 1'b0,
                 mem_we: 1'b0, branch: 1'b0, jump: 1'b0, alu_sel: ASEL_ADD};
        unique case (cls)
            CLS_RTYPE: begin
                ctrl.reg_we  = 1'b1;
                ctrl.dst_rd  = 1'b1;
                ctrl.alu_sel = ASEL_FUNCT;
            end
            CLS_LOAD: begin
                ctrl.reg_we  = 1'b1;
                ctrl.src_imm = 1'b1;
                ctrl.wb_mem  = 1'b1;
            end
            CLS_STORE: begin
                ctrl.src_imm = 1'b1;
                ctrl.mem_we  = 1'b1;
            end
            CLS_BRANCH: begin
                ctrl.branch  = 1'b1;
                ctrl.alu_sel = ASEL_SUB;
            end
            CLS_JUMP:  ctrl.jump = 1'b1;
            CLS_ADDI: begin
                ctrl.reg_we  = 1'b1;
                ctrl.src_imm = 1'b1;
            end
            CLS_NOP:   ctrl.reg_we = 1'b0;
        endcase
    end

endmodule

// File: rtl/sc_alu_dec.sv
module sc_alu_dec
    import sc_pkg::*;
(
    input  alu_sel_e   alu_sel,
    input  logic [5:0] funct,
    output alu_op_e    alu_op,
    output logic       op_valid
);

    always_comb begin
        op_valid = 1'b1;
        alu_op   = AOP_ADD;
        unique case (alu_sel)
            ASEL_ADD: alu_op = AOP_ADD;
            ASEL_SUB: alu_op = AOP_SUB;
            ASEL_FUNCT: begin
                unique case (funct)
                    FN_ADD: alu_op = AOP_ADD;
                    FN_SUB: alu_op = AOP_SUB;
                    FN_AND: alu_op = AOP_AND;
                    FN_OR:  alu_op = AOP_OR;
                    FN_SLT: alu_op = AOP_SLT;
                    default: begin
                        alu_op   = AOP_ADD;
                        op_valid = 1'b0;
                    end
                endcase
            end
            default: op_valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  alu_op_e          op,
    input  logic [XLEN-1:0]  a,
    input  logic [XLEN-1:0]  b,
    output logic [XLEN-1:0]  y,
    output logic             zero
);

    always_comb begin
        unique case (op)
            AOP_AND: y = a & b;
            AOP_OR:  y = a | b;
            AOP_ADD: y = a + b;
            AOP_SUB: y = a - b;
            AOP_SLT: y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
            AOP_NOR: y = ~(a | b);
            default: y = '0;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int XLEN = 32,
    parameter int NREG = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   ra_a,
    input  logic [AW-1:0]   ra_b,
    output logic [XLEN-1:0] rd_a,
    output logic [XLEN-1:0] rd_b,
    input  logic            we,
    input  logic [AW-1:0]   wa,
    input  logic [XLEN-1:0] wd
);

    logic [XLEN-1:0] regs [NREG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we && wa != '0) begin
            regs[wa] <= wd;
        end
    end

    assign rd_a = (ra_a == '0) ? '0 : regs[ra_a];
    assign rd_b = (ra_b == '0) ? '0 : regs[ra_b];

endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [XLEN-1:0] imem_addr,
    input  logic [31:0]     imem_rdata,
    output logic [XLEN-1:0] dmem_addr,
    output logic [XLEN-1:0] dmem_wdata,
    output logic            dmem_we,
    input  logic [XLEN-1:0] dmem_rdata
);

    localparam int NREG = 32;
    localparam int AW   = $clog2(NREG);
    localparam int IMMW = 16;
    localparam int TGTW = 26;

    logic [XLEN-1:0] pc_q, pc_d, pc_seq, br_tgt, jmp_tgt;
    logic [XLEN-1:0] src_a, src_b, alu_b, alu_y, imm_ext, wb_data;
    logic [AW-1:0]   f_rs, f_rt, f_rd, wr_addr;
    logic            alu_zero, fn_ok, wr_en;
    ins_cls_e        cls;
    ctrl_t           ctrl;
    alu_op_e         alu_op;

    assign f_rs    = imem_rdata[25:21];
    assign f_rt    = imem_rdata[20:16];
    assign f_rd    = imem_rdata[15:11];
    assign imm_ext = {{(XLEN-IMMW){imem_rdata[IMMW-1]}}, imem_rdata[IMMW-1:0]};

    sc_main_dec u_main_dec (
        .opcode (imem_rdata[31:26]),
        .cls    (cls),
        .ctrl   (ctrl)
    );

    sc_alu_dec u_alu_dec (
        .alu_sel  (ctrl.alu_sel),
        .funct    (imem_rdata[5:0]),
        .alu_op   (alu_op),
        .op_valid (fn_ok)
    );

    sc_regfile #(.XLEN(XLEN), .NREG(NREG)) u_regs (
        .clk  (clk),
        .rst_n(rst_n),
        .ra_a (f_rs),
        .ra_b (f_rt),
        .rd_a (src_a),
        .rd_b (src_b),
        .we   (wr_en),
        .wa   (wr_addr),
        .wd   (wb_data)
    );

    assign alu_b = ctrl.src_imm ? imm_ext : src_b;

    sc_alu #(.XLEN(XLEN)) u_alu (
        .op   (alu_op),
        .a    (src_a),
        .b    (alu_b),
        .y    (alu_y),
        .zero (alu_zero)
    );

    assign wr_en   = ctrl.reg_we & fn_ok;
    assign wr_addr = ctrl.dst_rd ? f_rd : f_rt;
    assign wb_data = ctrl.wb_mem ? dmem_rdata : alu_y;

    assign pc_seq  = pc_q + XLEN'(4);
    assign br_tgt  = pc_seq + {imm_ext[XLEN-3:0], 2'b00};
    assign jmp_tgt = {pc_q[XLEN-1:TGTW+2], imem_rdata[TGTW-1:0], 2'b00};

    // next-PC selection
    always_comb begin
        if (ctrl.jump)                   pc_d = jmp_tgt;
        else if (ctrl.branch && alu_zero) pc_d = br_tgt;
        else                             pc_d = pc_seq;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end

    // port outputs
    always_comb begin
        imem_addr  = pc_q;
        dmem_addr  = alu_y;
        dmem_wdata = src_b;
        dmem_we    = ctrl.mem_we && (cls == CLS_STORE);
    end

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [XLEN-1:0] imem_addr,
    input logic [31:0]     imem_rdata,
    input logic            dmem_we
);

    logic [5:0] opc;
    logic [XLEN-1:0] sext_sh;
    assign opc     = imem_rdata[31:26];
    assign sext_sh = {{(XLEN-18){imem_rdata[15]}}, imem_rdata[15:0], 2'b00};

    // R1
    first_fetch_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> imem_addr == '0);

    // R6
    strobe_only_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |-> opc == 6'd43);

    // R8
    jump_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        opc == 6'd2 |=> imem_addr == {$past(imem_addr[XLEN-1:28]), $past(imem_rdata[25:0]), 2'b00});

    // R7
    beq_self_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opc == 6'd4 && imem_rdata[25:21] == imem_rdata[20:16])
        |=> imem_addr == $past(imem_addr) + XLEN'(4) + $past(sext_sh));

    // R10
    undef_opcode_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(opc inside {6'd0, 6'd2, 6'd4, 6'd8, 6'd35, 6'd43})
        |=> imem_addr == $past(imem_addr) + XLEN'(4));

    // R5
    load_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        opc == 6'd35 |-> !dmem_we);

endmodule

bind sc_core sc_core_chk #(.XLEN(XLEN)) u_sc_core_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_we    (dmem_we)
);

// File: tb/tb_sc_core.sv
module tb_sc_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we;

    logic [31:0] imem [64];
    logic [31:0] dmem [64];

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    sc_core dut (
        .clk(clk), .rst_n(rst_n),
        .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
        .dmem_we(dmem_we), .dmem_rdata(dmem_rdata)
    );

    assign imem_rdata = imem[imem_addr[7:2]];
    assign dmem_rdata = dmem[dmem_addr[7:2]];

    always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, int fn);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
    endfunction
    function automatic logic [31:0] enc_i(int op, int rs, int rt, int imm);
        return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
    endfunction
    function automatic logic [31:0] enc_j(int idx);
        return {6'd2, 26'(idx)};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // behavioural reference state
    logic [31:0] m_reg [32];
    logic [31:0] m_mem [64];
    logic [31:0] m_pc;
    string       m_tag;

    function automatic string tag_of(logic [31:0] w);
        case (w[31:26])
            6'd0:  return (w[5:0] inside {6'd32, 6'd34, 6'd36, 6'd37, 6'd42}) ? "R2" : "R3";
            6'd8:  return "R4";
            6'd35: return "R5";
            6'd43: return "R6";
            6'd4:  return "R7";
            6'd2:  return "R8";
            default: return "R10";
        endcase
    endfunction

    task automatic model_step();
        logic [31:0] w, a, b, se, res, nxt;
        int   dst;
        bit   wr;
        w   = imem[m_pc[7:2]];
        a   = m_reg[w[25:21]];
        b   = m_reg[w[20:16]];
        se  = {{16{w[15]}}, w[15:0]};
        nxt = m_pc + 4;
        wr  = 0; dst = 0; res = 0;
        // compare this instruction's data-port outputs
        if (w[31:26] == 6'd43) begin
            check("R6 strobe", 32'(dmem_we), 32'd1);
            check("R6 address", dmem_addr, a + se);
            check("R6 data", dmem_wdata, b);
        end else begin
            check({tag_of(w), " strobe low"}, 32'(dmem_we), 32'd0);
        end
        case (w[31:26])
            6'd0: begin
                dst = w[15:11]; wr = 1;
                case (w[5:0])
                    6'd32: res = a + b;
                    6'd34: res = a - b;
                    6'd36: res = a & b;
                    6'd37: res = a | b;
                    6'd42: res = ($signed(a) < $signed(b)) ? 1 : 0;
                    default: wr = 0;
                endcase
            end
            6'd8:  begin dst = w[20:16]; wr = 1; res = a + se; end
            6'd35: begin dst = w[20:16]; wr = 1; res = m_mem[(a + se) >> 2]; end
            6'd43: m_mem[(a + se) >> 2] = b;
            6'd4:  if (a == b) nxt = m_pc + 4 + (se << 2);
            6'd2:  nxt = {m_pc[31:28], w[25:0], 2'b00};
            default: ;
        endcase
        if (wr && dst != 0) m_reg[dst] = res;
        m_tag = tag_of(w);
        m_pc  = nxt;
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin
            imem[i] = 32'h0; dmem[i] = 32'h0; m_mem[i] = 32'h0;
        end
        for (int i = 0; i < 32; i++) m_reg[i] = 32'h0;
        m_pc  = 0;
        m_tag = "R1";
        imem[0]  = enc_i(8, 0, 1, 5);
        imem[1]  = enc_i(8, 0, 2, -3);
        imem[2]  = enc_r(1, 2, 3, 32);
        imem[3]  = enc_r(1, 2, 4, 34);
        imem[4]  = enc_r(1, 2, 5, 36);
        imem[5]  = enc_r(1, 2, 6, 37);
        imem[6]  = enc_r(2, 1, 7, 42);
        imem[7]  = enc_r(1, 2, 8, 42);
        imem[8]  = enc_i(43, 0, 3, 8);
        imem[9]  = enc_i(35, 0, 9, 8);
        imem[10] = enc_i(43, 0, 9, 28);
        imem[11] = enc_i(8, 0, 0, 7);
        imem[12] = enc_i(43, 0, 0, 12);
        imem[13] = enc_r(1, 2, 10, 63);
        imem[14] = enc_i(63, 1, 10, 77);
        imem[15] = enc_i(43, 0, 10, 16);
        imem[16] = enc_i(4, 1, 2, 5);
        imem[17] = enc_i(4, 1, 1, 2);
        imem[18] = enc_i(8, 0, 11, 1);
        imem[19] = enc_i(8, 0, 11, 2);
        imem[20] = enc_i(43, 0, 11, 20);
        imem[21] = enc_i(8, 0, 12, -1);
        imem[22] = enc_i(8, 0, 13, 40);
        imem[23] = enc_i(43, 13, 12, -8);
        imem[24] = enc_j(27);
        imem[25] = enc_i(8, 0, 14, 99);
        imem[26] = enc_i(8, 0, 14, 99);
        imem[27] = enc_i(8, 14, 14, 1);
        imem[28] = enc_i(4, 14, 1, 1);
        imem[29] = enc_i(4, 0, 0, -3);
        imem[30] = enc_i(43, 0, 14, 24);
        imem[31] = enc_i(43, 0, 4, 36);
        imem[32] = enc_i(43, 0, 5, 40);
        imem[33] = enc_i(43, 0, 6, 44);
        imem[34] = enc_i(43, 0, 7, 48);
        imem[35] = enc_i(43, 0, 8, 52);
        imem[36] = enc_j(36);

        repeat (3) @(negedge clk);
        // R1: PC held at zero during reset
        check("R1 reset pc", imem_addr, 32'h0);
        rst_n = 1'b1;
        for (int cyc = 0; cyc < 100; cyc++) begin
            check({m_tag, " pc"}, imem_addr, m_pc);
            model_step();
            @(negedge clk);
        end
        check("R2 add via lw/sw path", dmem[2], 32'd2);
        check("R5 load then store", dmem[7], 32'd2);
        check("R9 zero register", dmem[3], 32'd0);
        check("R3 bad funct no write, R1 reset regs", dmem[4], 32'd0);
        check("R10 undefined opcode no write", dmem[4], 32'd0);
        check("R7 taken branch skipped writes", dmem[5], 32'd0);
        check("R7 backward loop count", dmem[6], 32'd5);
        check("R6 negative offset store", dmem[8], 32'hFFFF_FFFF);
        check("R2 sub", dmem[9], 32'd8);
        check("R2 and", dmem[10], 32'd5);
        check("R2 or", dmem[11], 32'hFFFF_FFFD);
        check("R2 slt true", dmem[12], 32'd1);
        check("R2 slt false", dmem[13], 32'd0);
        check("R8 jump parked", imem_addr, 32'd144);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(20 * 5000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule